// File: doc/BRIEF.md
# Lane-Aware Swap, Shift and Mask Unit

This unit rearranges a 32-bit operand in one pass and registers the result. It can leave the operand unchanged, shift it left or right, rotate it, swap its halves or bytes, or copy one half into both halves. The same operation can instead run on two independent 16-bit lanes. In that mode each lane is treated as a small word whose halves are bytes, and no bit moves from one lane into the other. The rearranged value then passes through an AND stage and then an OR stage. Each stage uses either a full-width mask from a port or a constant taken from the 5-bit immediate.

Operands arrive on a valid/ready stream and results leave on another. The output is a single register with a conditional load enable. An accepted beat whose load enable is low is consumed and discarded, and the register keeps its last contents. The zero-extended immediate is registered next to the result as a constant output. Back-pressure: `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, `out_data` and `out_const` hold their values and no new beat is accepted. `out_data` and `out_const` keep the last loaded values even while `out_valid` is low.

Top module: `swapmask_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` and `out_const` are 0, and `in_ready` is 1.
- R2: `mode` 3'b000 passes the operand through unchanged.
- R3: In full-word mode (`lane16`=0), `mode` 3'b001 shifts left and 3'b010 shifts right logically. Both take an amount of 0 to 31 from `imm[4:0]` and fill the vacated bits with zeros.
- R4: In full-word mode, `mode` 3'b011 rotates left by `imm[4:0]`. An amount of 0 leaves the operand unchanged.
- R5: In full-word mode, `mode` 3'b100 exchanges bits [31:16] and [15:0].
- R6: In full-word mode, `mode` 3'b101 reverses the order of the four bytes.
- R7: In full-word mode, `mode` 3'b110 copies bits [15:0] into both halves, and 3'b111 copies bits [31:16] into both halves.
- R8: With `lane16`=1, lane [31:16] and lane [15:0] are processed separately and no bit crosses between them. Shift and rotate use only `imm[3:0]`. Half swap and byte swap both exchange the two bytes of each lane. The duplicate modes copy the low or high byte of each lane into both bytes of that lane.
- R9: When `mask_cfg[3]` is 1, the rearranged value is ANDed with a mask. The mask is `and_mask` when `mask_cfg[2]` is 0, and the zero-extended `imm` when `mask_cfg[2]` is 1.
- R10: When `mask_cfg[1]` is 1, the result of the AND stage is ORed with a mask. The mask is `or_mask` when `mask_cfg[0]` is 0, and the zero-extended `imm` when `mask_cfg[0]` is 1.
- R11: An accepted beat with `ld_en`=0 changes neither `out_data` nor `out_const`, and it raises no `out_valid`.
- R12: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and both outputs hold. When `out_ready` rises, `in_ready` rises in the same cycle.
- R13: A loaded beat sets `out_const` to `imm` zero-extended to 32 bits, registered with the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat is present |
| in_ready | output | 1 | Unit can accept a beat |
| din | input | 32 | Operand |
| mode | input | 3 | Operation select (encoding in R2 to R7) |
| lane16 | input | 1 | 1 selects two independent 16-bit lanes |
| imm | input | 5 | Shift amount and constant source |
| ld_en | input | 1 | Conditional load enable of the output register |
| mask_cfg | input | 4 | {and enable, and uses constant, or enable, or uses constant} |
| and_mask | input | 32 | Port mask for the AND stage |
| or_mask | input | 32 | Port mask for the OR stage |
| out_valid | output | 1 | Result register holds an unread result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Registered result |
| out_const | output | 32 | Registered zero-extended constant |

## Verification
The lane boundary is the hardest thing to check from the ports. With ordinary operands, a lane shift gives nearly the same bits as a word shift, so a leak of one bit across bit 16 can go unnoticed. The stimulus therefore sets a single bit right next to the boundary and shifts it toward the other lane by one place, in both directions. It also feeds shift amounts with bit 4 set in lane mode, so a design that used the full 5-bit amount would give a visibly different word. The stall path is reached by holding `out_ready` low over a loaded result while a second beat waits at the input.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [2:0] {
    SM_PASS  = 3'b000,
    SM_SHL   = 3'b001,
    SM_SHR   = 3'b010,
    SM_ROT   = 3'b011,
    SM_HSWAP = 3'b100,
    SM_BSWAP = 3'b101,
    SM_DUPLO = 3'b110,
    SM_DUPHI = 3'b111
  } swm_mode_e;

  typedef struct packed {
    logic and_en;
    logic and_k;
    logic or_en;
    logic or_k;
  } swm_mask_cfg_t;
endpackage

// File: rtl/swm_rearr_core.sv
module swm_rearr_core
  import swm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]         x,
  input  logic [2:0]           op,
  input  logic [$clog2(W)-1:0] amt,
  output logic [W-1:0]         y
);
  localparam int H  = W / 2;
  localparam int NB = W / 8;

  logic [W-1:0]   byte_rev;
  logic [2*W-1:0] dbl_shift;
  swm_mode_e      op_e;

  assign op_e      = swm_mode_e'(op);
  assign dbl_shift = {x, x} << amt;

  for (genvar b = 0; b < NB; b++) begin : g_brev
    assign byte_rev[b*8 +: 8] = x[(NB-1-b)*8 +: 8];
  end

  always_comb begin
    unique case (op_e)
      SM_PASS:  y = x;
      SM_SHL:   y = x << amt;
      SM_SHR:   y = x >> amt;
      SM_ROT:   y = dbl_shift[2*W-1:W];
      SM_HSWAP: y = {x[H-1:0], x[W-1:H]};
      SM_BSWAP: y = byte_rev;
      SM_DUPLO: y = {x[H-1:0], x[H-1:0]};
      SM_DUPHI: y = {x[W-1:H], x[W-1:H]};
      default:  y = x;
    endcase
  end
endmodule

// File: rtl/swm_mask_stage.sv
module swm_mask_stage
  import swm_pkg::*;
#(
  parameter int DW = 32,
  parameter int KW = 5
) (
  input  logic [DW-1:0] v,
  input  logic [3:0]    cfg,
  input  logic [DW-1:0] and_mask,
  input  logic [DW-1:0] or_mask,
  input  logic [KW-1:0] imm,
  output logic [DW-1:0] kext,
  output logic [DW-1:0] y
);
  swm_mask_cfg_t c;
  logic [DW-1:0] and_term, or_term, after_and;

  assign c    = swm_mask_cfg_t'(cfg);
  assign kext = {{(DW-KW){1'b0}}, imm};

  always_comb begin
    and_term = '1;
    if (c.and_en) and_term = c.and_k ? kext : and_mask;
    or_term = '0;
    if (c.or_en) or_term = c.or_k ? kext : or_mask;
  end

  assign after_and = v & and_term;
  assign y         = after_and | or_term;
endmodule

// File: rtl/swm_out_stage.sv
module swm_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          ld_en,
  input  logic [DW-1:0] res,
  input  logic [DW-1:0] kext,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [DW-1:0] out_const
);
  logic fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_const <= '0;
    end else if (fire && ld_en) begin
      out_valid <= 1'b1;
      out_data  <= res;
      out_const <= kext;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/swapmask_unit.sv
module swapmask_unit #(
  parameter int DW = 32,
  parameter int KW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] din,
  input  logic [2:0]    mode,
  input  logic          lane16,
  input  logic [KW-1:0] imm,
  input  logic          ld_en,
  input  logic [3:0]    mask_cfg,
  input  logic [DW-1:0] and_mask,
  input  logic [DW-1:0] or_mask,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [DW-1:0] out_const
);
  localparam int LW   = DW / 2;
  localparam int SHW  = $clog2(DW);
  localparam int LSHW = $clog2(LW);

  logic [DW-1:0] word_res, lane_res, rearr, masked, kext;
  logic [SHW-1:0]  amt_full;
  logic [LSHW-1:0] amt_lane;

  assign amt_full = SHW'(imm);
  assign amt_lane = LSHW'(imm);

  swm_rearr_core #(.W(DW)) u_word (
    .x(din), .op(mode), .amt(amt_full), .y(word_res)
  );

  for (genvar l = 0; l < 2; l++) begin : g_lane
    swm_rearr_core #(.W(LW)) u_lane (
      .x(din[l*LW +: LW]), .op(mode), .amt(amt_lane), .y(lane_res[l*LW +: LW])
    );
  end

  assign rearr = lane16 ? lane_res : word_res;

  swm_mask_stage #(.DW(DW), .KW(KW)) u_mask (
    .v(rearr), .cfg(mask_cfg), .and_mask(and_mask), .or_mask(or_mask),
    .imm(imm), .kext(kext), .y(masked)
  );

  swm_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ld_en(ld_en), .res(masked), .kext(kext), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_const(out_const)
  );
endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
  parameter int DW = 32,
  parameter int KW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] din,
  input logic [2:0]    mode,
  input logic [KW-1:0] imm,
  input logic          ld_en,
  input logic [3:0]    mask_cfg,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [DW-1:0] out_const
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_const)); // R12
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R12
  AST_SKIP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !ld_en |=> !out_valid && $stable(out_data) && $stable(out_const)); // R11
  AST_CONST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ld_en |=> out_valid && out_const == DW'($past(imm))); // R13
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ld_en && mode == 3'b000 && !mask_cfg[3] && !mask_cfg[1]
    |=> out_data == $past(din)); // R2
endmodule

bind swapmask_unit swm_checker #(.DW(DW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .din(din), .mode(mode), .imm(imm), .ld_en(ld_en), .mask_cfg(mask_cfg),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_const(out_const)
);

// File: tb/test_swapmask_unit.sv
module test_swapmask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] din = '0;
  logic [2:0]  mode = '0;
  logic        lane16 = 1'b0;
  logic [4:0]  imm = '0;
  logic        ld_en = 1'b1;
  logic [3:0]  mask_cfg = '0;
  logic [31:0] and_mask = 32'hFFFF_00FF;
  logic [31:0] or_mask  = 32'h8000_0000;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data, out_const;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  swapmask_unit i_swapmask_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .din(din), .mode(mode), .lane16(lane16), .imm(imm), .ld_en(ld_en),
    .mask_cfg(mask_cfg), .and_mask(and_mask), .or_mask(or_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_const(out_const)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        lane;
    logic [4:0]  imm;
    logic [31:0] din;
    logic [3:0]  mcfg;
    logic [31:0] exp;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b0, 5'd0,  32'h1234_5678, 4'b0000, 32'h1234_5678, 4'd2},
    '{3'd1, 1'b0, 5'd4,  32'h1234_5678, 4'b0000, 32'h2345_6780, 4'd3},
    '{3'd1, 1'b0, 5'd20, 32'h1234_5678, 4'b0000, 32'h6780_0000, 4'd3},
    '{3'd2, 1'b0, 5'd8,  32'h1234_5678, 4'b0000, 32'h0012_3456, 4'd3},
    '{3'd1, 1'b0, 5'd31, 32'h0000_0003, 4'b0000, 32'h8000_0000, 4'd3},
    '{3'd2, 1'b0, 5'd31, 32'h8000_0000, 4'b0000, 32'h0000_0001, 4'd3},
    '{3'd3, 1'b0, 5'd8,  32'h1234_5678, 4'b0000, 32'h3456_7812, 4'd4},
    '{3'd3, 1'b0, 5'd0,  32'h1234_5678, 4'b0000, 32'h1234_5678, 4'd4},
    '{3'd4, 1'b0, 5'd0,  32'h1234_5678, 4'b0000, 32'h5678_1234, 4'd5},
    '{3'd5, 1'b0, 5'd0,  32'h1234_5678, 4'b0000, 32'h7856_3412, 4'd6},
    '{3'd6, 1'b0, 5'd0,  32'h1234_5678, 4'b0000, 32'h5678_5678, 4'd7},
    '{3'd7, 1'b0, 5'd0,  32'h1234_5678, 4'b0000, 32'h1234_1234, 4'd7},
    '{3'd1, 1'b1, 5'd20, 32'h1234_5678, 4'b0000, 32'h2340_6780, 4'd8},
    '{3'd2, 1'b1, 5'd8,  32'h1234_5678, 4'b0000, 32'h0012_0056, 4'd8},
    '{3'd3, 1'b1, 5'd4,  32'h1234_5678, 4'b0000, 32'h2341_6785, 4'd8},
    '{3'd4, 1'b1, 5'd0,  32'h1234_5678, 4'b0000, 32'h3412_7856, 4'd8},
    '{3'd5, 1'b1, 5'd0,  32'h1234_5678, 4'b0000, 32'h3412_7856, 4'd8},
    '{3'd6, 1'b1, 5'd0,  32'h1234_5678, 4'b0000, 32'h3434_7878, 4'd8},
    '{3'd7, 1'b1, 5'd0,  32'h1234_5678, 4'b0000, 32'h1212_5656, 4'd8},
    '{3'd2, 1'b1, 5'd1,  32'h0001_0000, 4'b0000, 32'h0000_0000, 4'd8},
    '{3'd1, 1'b1, 5'd1,  32'h0000_8000, 4'b0000, 32'h0000_0000, 4'd8},
    '{3'd0, 1'b0, 5'd0,  32'h1234_5678, 4'b1000, 32'h1234_0078, 4'd9},
    '{3'd0, 1'b0, 5'd31, 32'h1234_5678, 4'b1100, 32'h0000_0018, 4'd9},
    '{3'd1, 1'b0, 5'd4,  32'h1234_5678, 4'b1000, 32'h2345_0080, 4'd9},
    '{3'd0, 1'b0, 5'd0,  32'h1234_5678, 4'b1010, 32'h9234_0078, 4'd10},
    '{3'd0, 1'b0, 5'd21, 32'h1234_5678, 4'b0011, 32'h1234_567D, 4'd10}
  };

  function automatic string tagname(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 out_data", out_data, 32'd0);
    chk("R1 out_const", out_const, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      mode     = TBL[i].mode;
      lane16   = TBL[i].lane;
      imm      = TBL[i].imm;
      din      = TBL[i].din;
      mask_cfg = TBL[i].mcfg;
      @(negedge clk);
      chk(tagname(TBL[i].tag), out_data, TBL[i].exp);
      chk({tagname(TBL[i].tag), " valid"}, {31'd0, out_valid}, 32'd1);
    end

    // R13: constant register carries the zero-extended immediate of the last load
    chk("R13 const", out_const, 32'h0000_0015);

    // R11: accepted beat with load enable low leaves the register untouched
    @(negedge clk);
    ld_en = 1'b0; mode = 3'd0; lane16 = 1'b0; mask_cfg = 4'b0000;
    din = 32'hDEAD_BEEF; imm = 5'd7;
    @(negedge clk);
    chk("R11 data", out_data, 32'h1234_567D);
    chk("R11 const", out_const, 32'h0000_0015);
    chk("R11 valid", {31'd0, out_valid}, 32'd0);

    // R12: stall with a waiting beat
    out_ready = 1'b0; ld_en = 1'b1; din = 32'h1111_1111; imm = 5'd3;
    @(negedge clk);
    chk("R12 first", out_data, 32'h1111_1111);
    chk("R13 const3", out_const, 32'h0000_0003);
    chk("R12 ready low", {31'd0, in_ready}, 32'd0);
    din = 32'h2222_2222; imm = 5'd9;
    @(negedge clk);
    @(negedge clk);
    chk("R12 hold data", out_data, 32'h1111_1111);
    chk("R12 hold const", out_const, 32'h0000_0003);
    chk("R12 hold valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    #1;
    chk("R12 ready rise", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    chk("R12 next", out_data, 32'h2222_2222);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R12 drained", {31'd0, out_valid}, 32'd0);
    finish_run();
  end
endmodule